// File: doc/BRIEF.md
# Event Cause, Mask and Soft-Reset Register Unit

This block gathers seven event lines into a sticky cause register, qualifies them with an enable mask and raises one combined interrupt toward a parent interrupt controller whenever an enabled cause bit is set. An event line, whether it is held high or pulses for a single cycle, sets its cause bit. The bit then stays set until software clears it.

The cause register is plain read/write, not write-one-to-clear. Software reads it, clears the bits it has handled and writes the result back. Writing a 1 raises an event from software. A hardware event that lands in the same cycle as that write-back is kept.

The same register port reaches a 32-bit soft-reset register. Each of its bits drives an active-low reset line into a subsystem. Software pulses a reset by writing the bit to 0 and then writing it back to 1. An asynchronous active-low reset initialises the block, and the block leaves reset synchronously to its clock.

Top module: `event_cause_unit`

## Requirements
- R1: During reset and after it is released, the cause register and the mask register read 0, every `sub_rst_n` bit is 1 and `irq_out` is 0.
- R2: Register byte offsets: 0x50 selects the cause register, 0x54 the mask register and 0x30 the soft-reset register. Any other offset reads 0, and a write to it changes no register.
- R3: A write to the cause register (`reg_wr`=1, `reg_addr`=0x50) loads `reg_wdata[6:0]` at that clock edge. A 1 sets a bit, so software can raise an event; a 0 clears a bit.
- R4: `event_in[i]` high at a clock edge sets cause bit i at that edge. The bit stays set until a software write clears it. When a write of 0 to bit i arrives in the same cycle as `event_in[i]`, the bit ends up set.
- R5: A write to the mask register loads `reg_wdata[6:0]`. Mask bit i at 1 enables source i and at 0 blocks it.
- R6: `irq_out` is 1 exactly when the bitwise AND of cause and mask is nonzero. It follows the registers in the same cycle, with no added delay.
- R7: Reads of the cause and mask registers return 0 in bits 31:7. Writes to those bits have no effect.
- R8: A write to the soft-reset register drives `reg_wdata[31:0]` onto `sub_rst_n` from that clock edge on. A write that clears a bit followed by a write that sets it produces a one-write-long low pulse on that line.
- R9: `reg_rdata` shows the register selected by `reg_addr` in the same cycle, with no read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_addr | input | 8 | Register byte offset |
| reg_wr | input | 1 | Write strobe, sampled at the rising clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the register at `reg_addr` |
| event_in | input | 7 | Event sources, active high |
| irq_out | output | 1 | Combined interrupt to the parent controller |
| sub_rst_n | output | 32 | Active-low subsystem reset lines |

## Verification
The checker tests a set of rules on every cycle:
- every sampled event appears in the cause register one edge later;
- the cause register holds its value, apart from newly set event bits, when no write targets it;
- a cause write combines with events that arrive in the same cycle;
- mask and soft-reset writes land as written;
- `irq_out` matches the AND of cause and mask;
- the high read bits of cause and mask are zero.

Some behaviour can only be shown through the bench's scenarios:
- the reset values;
- the same-cycle collision between an event and a clearing write;
- a complete soft-reset pulse on one line;
- writes to unmapped offsets leaving every register unchanged;
- the read-modify-write clearing flow.

// File: rtl/evtu_pkg.sv
package evtu_pkg;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 32;
  localparam logic [ADDR_W-1:0] OFF_SWRST = 8'h30;
  localparam logic [ADDR_W-1:0] OFF_CAUSE = 8'h50;
  localparam logic [ADDR_W-1:0] OFF_MASK  = 8'h54;

  typedef struct packed {
    logic cause;
    logic mask;
    logic swrst;
  } reg_sel_t;
endpackage

// File: rtl/evtu_rst_sync.sv
module evtu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/evtu_addr_dec.sv
module evtu_addr_dec
  import evtu_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  output reg_sel_t          rd_sel,
  output reg_sel_t          wr_sel
);
  always_comb begin
    rd_sel.cause = (addr == OFF_CAUSE);
    rd_sel.mask  = (addr == OFF_MASK);
    rd_sel.swrst = (addr == OFF_SWRST);
    wr_sel.cause = wr & rd_sel.cause;
    wr_sel.mask  = wr & rd_sel.mask;
    wr_sel.swrst = wr & rd_sel.swrst;
  end
endmodule

// File: rtl/evtu_cause_reg.sv
module evtu_cause_reg #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [N-1:0] wdata,
  input  logic [N-1:0] event_in,
  output logic [N-1:0] cause_q
);
  logic [N-1:0] cause_d;
  logic [N-1:0] cause_en;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_comb begin
      cause_en[i] = wr_en | event_in[i];
      if (event_in[i])  cause_d[i] = 1'b1;
      else if (wr_en)   cause_d[i] = wdata[i];
      else              cause_d[i] = cause_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cause_q[i] <= 1'b0;
      else if (cause_en[i])  cause_q[i] <= cause_d[i];
    end
  end
endmodule

// File: rtl/evtu_plain_reg.sv
module evtu_plain_reg #(
  parameter int            W        = 7,
  parameter logic [W-1:0]  RST_VAL  = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  logic [W-1:0] d;

  always_comb begin
    d = wr_en ? wdata : q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= RST_VAL;
    else if (wr_en) q <= d;
  end
endmodule

// File: rtl/evtu_irq_combine.sv
module evtu_irq_combine #(
  parameter int N = 7
) (
  input  logic [N-1:0] cause,
  input  logic [N-1:0] mask,
  output logic         irq
);
  logic [N-1:0] pend;

  always_comb begin
    pend = cause & mask;
    irq  = |pend;
  end
endmodule

// File: rtl/evtu_rd_mux.sv
module evtu_rd_mux
  import evtu_pkg::*;
#(
  parameter int N     = 7,
  parameter int RST_W = 32
) (
  input  reg_sel_t           sel,
  input  logic [N-1:0]       cause,
  input  logic [N-1:0]       mask,
  input  logic [RST_W-1:0]   swrst,
  output logic [DATA_W-1:0]  rdata
);
  always_comb begin
    rdata = '0;
    if (sel.cause)      rdata = DATA_W'(cause);
    else if (sel.mask)  rdata = DATA_W'(mask);
    else if (sel.swrst) rdata = DATA_W'(swrst);
  end
endmodule

// File: rtl/event_cause_unit.sv
module event_cause_unit
  import evtu_pkg::*;
#(
  parameter int NUM_SRC = 7,
  parameter int RST_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        reg_addr,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [NUM_SRC-1:0] event_in,
  output logic              irq_out,
  output logic [RST_W-1:0]  sub_rst_n
);
  logic               rst_sync_n;
  reg_sel_t           rd_sel;
  reg_sel_t           wr_sel;
  logic [NUM_SRC-1:0] cause_q;
  logic [NUM_SRC-1:0] mask_q;

  evtu_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  evtu_addr_dec u_dec (
    .addr(reg_addr), .wr(reg_wr), .rd_sel(rd_sel), .wr_sel(wr_sel)
  );

  evtu_cause_reg #(.N(NUM_SRC)) u_cause (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_sel.cause),
    .wdata(reg_wdata[NUM_SRC-1:0]), .event_in(event_in), .cause_q(cause_q)
  );

  evtu_plain_reg #(.W(NUM_SRC), .RST_VAL('0)) u_mask (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_sel.mask),
    .wdata(reg_wdata[NUM_SRC-1:0]), .q(mask_q)
  );

  evtu_plain_reg #(.W(RST_W), .RST_VAL('1)) u_swrst (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_sel.swrst),
    .wdata(reg_wdata[RST_W-1:0]), .q(sub_rst_n)
  );

  evtu_irq_combine #(.N(NUM_SRC)) u_irq (
    .cause(cause_q), .mask(mask_q), .irq(irq_out)
  );

  evtu_rd_mux #(.N(NUM_SRC), .RST_W(RST_W)) u_rd (
    .sel(rd_sel), .cause(cause_q), .mask(mask_q), .swrst(sub_rst_n),
    .rdata(reg_rdata)
  );
endmodule

// File: rtl/evtu_checker.sv
module evtu_checker
  import evtu_pkg::*;
#(
  parameter int N     = 7,
  parameter int RST_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [7:0]        reg_addr,
  input logic              reg_wr,
  input logic [31:0]       reg_wdata,
  input logic [31:0]       reg_rdata,
  input logic [N-1:0]      event_in,
  input logic              irq_out,
  input logic [RST_W-1:0]  sub_rst_n,
  input logic [N-1:0]      cause_q,
  input logic [N-1:0]      mask_q
);
  logic past_ok;
  logic wr_cause, wr_mask, wr_swrst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  assign wr_cause = reg_wr && (reg_addr == OFF_CAUSE);
  assign wr_mask  = reg_wr && (reg_addr == OFF_MASK);
  assign wr_swrst = reg_wr && (reg_addr == OFF_SWRST);

  // R4: every sampled event is present in cause one edge later
  a_r4_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> ((cause_q & $past(event_in)) == $past(event_in)));

  // R4: without a cause write the register only gains event bits
  a_r4_cause_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(!wr_cause)) |-> (cause_q == ($past(cause_q) | $past(event_in))));

  // R3: a cause write loads data, events merged on top
  a_r3_cause_write: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(wr_cause)) |-> (cause_q == ($past(reg_wdata[N-1:0]) | $past(event_in))));

  // R5: a mask write loads data
  a_r5_mask_write: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(wr_mask)) |-> (mask_q == $past(reg_wdata[N-1:0])));

  // R8: a soft-reset write drives the lines
  a_r8_swrst_write: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(wr_swrst)) |-> (sub_rst_n == $past(reg_wdata[RST_W-1:0])));

  // R6: combined interrupt matches enabled causes
  a_r6_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == (|(cause_q & mask_q)));

  // R7: high read bits of cause and mask are zero
  a_r7_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ((reg_addr == OFF_CAUSE) || (reg_addr == OFF_MASK)) |-> ((reg_rdata >> N) == 32'd0));
endmodule

bind event_cause_unit evtu_checker #(.N(NUM_SRC), .RST_W(RST_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .event_in(event_in),
  .irq_out(irq_out), .sub_rst_n(sub_rst_n), .cause_q(cause_q), .mask_q(mask_q)
);

// File: tb/tb_event_cause_unit.sv
`timescale 1ns/1ps
module tb_event_cause_unit;
  localparam int N = 7;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  reg_addr;
  logic        reg_wr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [N-1:0] event_in;
  logic        irq_out;
  logic [31:0] sub_rst_n;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [N-1:0] m_cause;
  logic [N-1:0] m_mask;
  logic [31:0]  m_swrst;

  always #2.5 clk = ~clk;

  event_cause_unit dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .event_in(event_in),
    .irq_out(irq_out), .sub_rst_n(sub_rst_n)
  );

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    case (a)
      8'h50:   return {25'd0, m_cause};
      8'h54:   return {25'd0, m_mask};
      8'h30:   return m_swrst;
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one clock: drive at negedge, update model at posedge
  task automatic step(input logic wr, input logic [7:0] a, input logic [31:0] d,
                      input logic [N-1:0] ev);
    @(negedge clk);
    reg_wr = wr; reg_addr = a; reg_wdata = d; event_in = ev;
    @(posedge clk);
    if (wr && a == 8'h50) m_cause = d[N-1:0];
    if (wr && a == 8'h54) m_mask  = d[N-1:0];
    if (wr && a == 8'h30) m_swrst = d;
    m_cause = m_cause | ev;
    #0.5;
    reg_wr = 1'b0; event_in = '0;
  endtask

  task automatic check_all(input string tag);
    check({tag, " R6 irq"}, {31'd0, irq_out}, {31'd0, |(m_cause & m_mask)});
    check({tag, " R8 lines"}, sub_rst_n, m_swrst);
    reg_addr = 8'h50; #0.2;
    check({tag, " R9 cause read"}, reg_rdata, exp_read(8'h50));
    reg_addr = 8'h54; #0.2;
    check({tag, " R9 mask read"}, reg_rdata, exp_read(8'h54));
    reg_addr = 8'h30; #0.2;
    check({tag, " R9 swrst read"}, reg_rdata, exp_read(8'h30));
  endtask

  initial begin
    void'($urandom(32'h1234_5678));
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0; event_in = '0;
    m_cause = '0; m_mask = '0; m_swrst = '1;
    repeat (3) @(posedge clk);
    #1;
    check("R1 irq in reset", {31'd0, irq_out}, 32'd0);
    check("R1 lines in reset", sub_rst_n, 32'hFFFF_FFFF);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #0.5;
    check_all("R1 after reset");

    // R3 software raise, R5 mask enable, R6
    step(1'b1, 8'h50, 32'h0000_0005, '0); check_all("R3 set");
    step(1'b1, 8'h54, 32'h0000_0004, '0); check_all("R5 enable");
    step(1'b1, 8'h54, 32'h0000_0002, '0); check_all("R5 block");
    // R7 upper bits ignored
    step(1'b1, 8'h54, 32'hFFFF_FF80, '0); check_all("R7 mask upper");
    step(1'b1, 8'h50, 32'hABCD_EF00, '0); check_all("R7 cause upper");
    // R4 pulse event sticks
    step(1'b1, 8'h54, 32'h0000_0040, '0);
    step(1'b0, 8'h00, 32'h0, 7'h40); check_all("R4 pulse");
    step(1'b0, 8'h00, 32'h0, '0);    check_all("R4 sticky");
    check("R4 sticky irq", {31'd0, irq_out}, 32'd1);
    // R4 collision: clear write while event 1 active
    step(1'b1, 8'h50, 32'h0, 7'h02); check_all("R4 collision");
    check("R4 collision bit", {31'd0, m_cause[1]}, 32'd1);
    // R2 unmapped write changes nothing
    step(1'b1, 8'h58, 32'hFFFF_FFFF, '0); check_all("R2 unmapped");
    reg_addr = 8'h58; #0.2;
    check("R2 unmapped read", reg_rdata, 32'd0);
    // R8 reset pulse on line 16
    step(1'b1, 8'h30, 32'hFFFE_FFFF, '0); check_all("R8 pulse low");
    check("R8 line16 low", {31'd0, sub_rst_n[16]}, 32'd0);
    step(1'b1, 8'h30, 32'hFFFF_FFFF, '0); check_all("R8 pulse high");

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [7:0] a;
      logic [N-1:0] ev;
      case ($urandom_range(0, 3))
        0: a = 8'h50;
        1: a = 8'h54;
        2: a = 8'h30;
        default: a = 8'($urandom);
      endcase
      ev = ($urandom_range(0, 3) == 0) ? N'($urandom) : '0;
      step(1'($urandom), a, $urandom, ev);
      check_all("R3 R4 R5 random");
    end
    done = 1'b1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (50000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule